// File: doc/BRIEF.md
# Two-Phase Command Frame Decoder

This block sits at the front of a search-engine device. It receives operations from a host controller over a 9-bit command bus that a valid strobe qualifies, and it runs on the double-rate clock. Each operation spans two consecutive strobed cycles, phase A and phase B. The block keeps phase A in a register. When phase B arrives it checks both words together and splits them into an operation code and its parameters: the upper SRAM address bits, the global mask register index, single or burst access, the comparand register index, the result register index and the learn width.

The result is a one-cycle `dec_valid` pulse with a parameter bundle, or a one-cycle `dec_err` pulse. The bundle reads as zero in every cycle without a pulse. A static `width_cfg` input gives the entry width (68, 136 or 272 bits), and the checks for search and learn depend on it. Executing the operation is done elsewhere.

The controller is a two-state machine. `ST_IDLE` waits for a strobe. On `T_START` (strobe high) it stores phase A and moves to `ST_WAIT_B`. From `ST_WAIT_B` it always returns to `ST_IDLE`, by one of two transitions:
- `T_FINISH`: the strobe is high, so the word is phase B and is evaluated.
- `T_ABORT`: the strobe is low, so the frame is broken.

Because `ST_IDLE` is entered in the cycle that the result pulse shows, a new phase A is accepted in that same cycle.

Top module: `cmd_frame_decoder`

## Requirements
- R1: After reset, `dec_valid` and `dec_err` are low and all bundle outputs are zero.
- R2: A frame is two consecutive cycles with `cmd_valid` high. The outcome pulse (`dec_valid` or `dec_err`) lasts exactly one cycle, in the cycle after phase B. It never lasts two cycles in a row, and bundle outputs are zero whenever `dec_valid` is low.
- R3: Bits [1:0] carry the operation code: 00 read, 01 write, 10 search, 11 learn. If the code in phase B differs from the code in phase A, the frame produces `dec_err`.
- R4: If `cmd_valid` is low in the cycle after phase A, `dec_err` pulses in the next cycle and the block returns to idle, so that the next strobed cycle is taken as phase A.
- R5: For read and write, `dec_sadr_hi` is phase A bits [8:7] (address bits 21:20) and `dec_burst` is bit 2 (0 single, 1 burst). For write, `dec_gmr_idx` is phase A bits [5:3]. Phase A bit 6 (address bit 19) appears on no output.
- R6: A read needs phase A bits [5:3] and phase B bits [8:3] to be zero. A write needs phase B bits [8:6] to be zero. Any nonzero bit in these fields gives `dec_err`.
- R7: For search:
  - `dec_gmr_idx` is phase A [5:3], `dec_res_idx` is phase B [8:6] and `dec_cmp_idx` is phase B [5:3].
  - Phase B bit 2 must be 0.
  - Phase A bit 2 must be 1 when `width_cfg[1]`=1 (272-bit) and 0 otherwise (`width_cfg` 00 = 68-bit, 01 = 136-bit).
  - Any other value gives `dec_err`.
- R8: For learn:
  - `dec_cmp_idx` is bits [5:3] and `dec_learn_wide` is phase B bit 7 (0 = 68-bit, 1 = 136-bit).
  - Phase B bits 8 and 6, and bit 2 of both phases, must be zero.
  - A learn while `width_cfg[1]`=1 gives `dec_err`.
- R9: Fields that both phases carry must hold the same value in each: bit 2 for read and write, bits [5:3] for write and learn. A difference gives `dec_err`.
- R10: A phase A presented in the cycle of an outcome pulse is accepted, so back-to-back frames complete every two cycles.
- R11: `dec_valid` and `dec_err` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_bus | input | 9 | Command word: operation code in [1:0], parameters in [8:2] |
| width_cfg | input | 2 | Entry width: 00 = 68, 01 = 136, 1x = 272 |
| dec_valid | output | 1 | One-cycle pulse for a well-formed command |
| dec_err | output | 1 | One-cycle pulse for a rejected or broken frame |
| dec_op | output | 2 | Decoded operation code |
| dec_sadr_hi | output | 2 | SRAM address bits 21:20 |
| dec_gmr_idx | output | 3 | Global mask register index |
| dec_burst | output | 1 | Burst access (1) or single (0) |
| dec_cmp_idx | output | 3 | Comparand register index |
| dec_res_idx | output | 3 | Result register index for a search |
| dec_learn_wide | output | 1 | Learn width: 136-bit (1) or 68-bit (0) |

## Verification
An outcome pulse and the acceptance of the next phase A fall in the same cycle whenever frames are sent back to back. The bench sends most of its frames with no gap, so each result is registered while the state machine is already storing the next phase A. It checks the pulse in the cycle after each phase B and checks that no pulse is present in the cycle after the following phase A. The same overlap occurs after a broken frame: a fresh phase A follows the error cycle at once, and that frame must still decode as expected.

// File: rtl/cmdfd_pkg.sv
package cmdfd_pkg;

    localparam int CMD_W = 9;
    localparam int OP_W  = 2;
    localparam int IDX_W = 3;
    localparam int SADR_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_READ   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_SEARCH = 2'b10,
        OP_LEARN  = 2'b11
    } op_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [SADR_W-1:0] sadr_hi;
        logic [IDX_W-1:0]  gmr_idx;
        logic              burst;
        logic [IDX_W-1:0]  cmp_idx;
        logic [IDX_W-1:0]  res_idx;
        logic              learn_wide;
    } dec_bundle_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_WAIT_B = 1'b1
    } fsm_state_e;

endpackage

// File: rtl/cmdfd_phase_fsm.sv
module cmdfd_phase_fsm
    import cmdfd_pkg::*;
#(
    parameter int W = CMD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_valid,
    input  logic [W-1:0] cmd_bus,
    output logic [W-1:0] phase_a,
    output logic         in_wait_b,
    output logic         do_eval,
    output logic         do_abort
);

    fsm_state_e state_q, state_d;
    logic [W-1:0] phase_a_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            phase_a_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cmd_valid) begin
                phase_a_q <= cmd_bus;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d  = state_q;
        do_eval  = 1'b0;
        do_abort = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    state_d = ST_WAIT_B;       // T_START
                end
            end
            ST_WAIT_B: begin
                state_d = ST_IDLE;
                if (cmd_valid) begin
                    do_eval = 1'b1;            // T_FINISH
                end else begin
                    do_abort = 1'b1;           // T_ABORT
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign phase_a   = phase_a_q;
    assign in_wait_b = (state_q == ST_WAIT_B);

    // R4: a frame never waits more than one cycle for phase B
    p_wait_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_B) |=> (state_q == ST_IDLE));

    p_eval_abort_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_eval && do_abort));

endmodule

// File: rtl/cmdfd_field_check.sv
module cmdfd_field_check
    import cmdfd_pkg::*;
#(
    parameter int W = CMD_W
) (
    input  logic [W-1:0]  word_a,
    input  logic [W-1:0]  word_b,
    input  logic [1:0]    width_cfg,
    output logic          frame_ok,
    output dec_bundle_t   bundle
);

    localparam int OP_LO  = 0;
    localparam int MOD_B  = OP_W;          // bit 2
    localparam int IDX_LO = OP_W + 1;      // bits [5:3]
    localparam int IDX_HI = IDX_LO + IDX_W - 1;
    localparam int HI_LO  = IDX_HI + 1;    // bits [8:6]
    localparam int HI_HI  = W - 1;

    logic            is_wide272;
    logic            cfg_unused;
    logic            sadr19_unused;
    logic [OP_W-1:0] op_a, op_b;
    logic            mode_a, mode_b;
    logic [IDX_W-1:0] idx_a, idx_b, hi_a, hi_b;
    logic            op_agree;
    logic            field_ok;

    assign is_wide272    = width_cfg[1];
    assign cfg_unused    = width_cfg[0];
    assign sadr19_unused = word_a[HI_LO];

    assign op_a   = word_a[OP_LO +: OP_W];
    assign op_b   = word_b[OP_LO +: OP_W];
    assign mode_a = word_a[MOD_B];
    assign mode_b = word_b[MOD_B];
    assign idx_a  = word_a[IDX_HI:IDX_LO];
    assign idx_b  = word_b[IDX_HI:IDX_LO];
    assign hi_a   = word_a[HI_HI:HI_LO];
    assign hi_b   = word_b[HI_HI:HI_LO];

    assign op_agree = (op_a == op_b);

    always_comb begin
        field_ok = 1'b0;
        bundle   = '0;
        bundle.op      = op_a;
        bundle.sadr_hi = hi_a[IDX_W-1 -: SADR_W];
        unique case (op_e'(op_a))
            OP_READ: begin
                field_ok     = (idx_a == '0) && (idx_b == '0) &&
                               (hi_b == '0) && (mode_a == mode_b);
                bundle.burst = mode_a;
            end
            OP_WRITE: begin
                field_ok       = (hi_b == '0) && (idx_a == idx_b) &&
                                 (mode_a == mode_b);
                bundle.burst   = mode_a;
                bundle.gmr_idx = idx_a;
            end
            OP_SEARCH: begin
                field_ok       = (mode_b == 1'b0) && (mode_a == is_wide272);
                bundle.gmr_idx = idx_a;
                bundle.res_idx = hi_b;
                bundle.cmp_idx = idx_b;
            end
            OP_LEARN: begin
                field_ok          = !is_wide272 && !mode_a && !mode_b &&
                                    !hi_b[2] && !hi_b[0] && (idx_a == idx_b);
                bundle.cmp_idx    = idx_a;
                bundle.learn_wide = hi_b[1];
            end
            default: field_ok = 1'b0;
        endcase
    end

    assign frame_ok = op_agree && field_ok;

    // R8: learn is never accepted in the wide configuration
    always_comb begin
        if (frame_ok && is_wide272) begin
            a_learn272_r8: assert (op_a != OP_LEARN);
        end
    end

endmodule

// File: rtl/cmdfd_out_reg.sv
module cmdfd_out_reg
    import cmdfd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        do_eval,
    input  logic        do_abort,
    input  logic        frame_ok,
    input  dec_bundle_t bundle_in,
    output logic        valid_q,
    output logic        err_q,
    output dec_bundle_t bundle_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            err_q    <= 1'b0;
            bundle_q <= '0;
        end else begin
            valid_q  <= do_eval && frame_ok;
            err_q    <= do_abort || (do_eval && !frame_ok);
            bundle_q <= (do_eval && frame_ok) ? bundle_in : '0;
        end
    end

    // R2: bundle is quiet without a pulse
    p_bundle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> (bundle_q == '0));

    // R2: no two outcome pulses in a row
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q || err_q) |=> !(valid_q || err_q));

    // R11
    p_valid_err_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_q && err_q));

endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder
    import cmdfd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [8:0]       cmd_bus,
    input  logic [1:0]       width_cfg,
    output logic             dec_valid,
    output logic             dec_err,
    output logic [1:0]       dec_op,
    output logic [1:0]       dec_sadr_hi,
    output logic [2:0]       dec_gmr_idx,
    output logic             dec_burst,
    output logic [2:0]       dec_cmp_idx,
    output logic [2:0]       dec_res_idx,
    output logic             dec_learn_wide
);

    logic [CMD_W-1:0] phase_a;
    logic             in_wait_b;
    logic             do_eval;
    logic             do_abort;
    logic             frame_ok;
    dec_bundle_t      bundle_c;
    dec_bundle_t      bundle_q;

    cmdfd_phase_fsm #(.W(CMD_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_bus   (cmd_bus),
        .phase_a   (phase_a),
        .in_wait_b (in_wait_b),
        .do_eval   (do_eval),
        .do_abort  (do_abort)
    );

    cmdfd_field_check #(.W(CMD_W)) u_check (
        .word_a    (phase_a),
        .word_b    (cmd_bus),
        .width_cfg (width_cfg),
        .frame_ok  (frame_ok),
        .bundle    (bundle_c)
    );

    cmdfd_out_reg u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_eval   (do_eval),
        .do_abort  (do_abort),
        .frame_ok  (frame_ok),
        .bundle_in (bundle_c),
        .valid_q   (dec_valid),
        .err_q     (dec_err),
        .bundle_q  (bundle_q)
    );

    assign dec_op         = bundle_q.op;
    assign dec_sadr_hi    = bundle_q.sadr_hi;
    assign dec_gmr_idx    = bundle_q.gmr_idx;
    assign dec_burst      = bundle_q.burst;
    assign dec_cmp_idx    = bundle_q.cmp_idx;
    assign dec_res_idx    = bundle_q.res_idx;
    assign dec_learn_wide = bundle_q.learn_wide;

    // R4: strobe dropped after phase A yields an error
    p_drop_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait_b && !cmd_valid) |=> dec_err);

    // R3: opcode disagreement yields an error
    p_op_mismatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait_b && cmd_valid && (cmd_bus[1:0] != phase_a[1:0])) |=> dec_err);

    // R8: learn in wide configuration yields an error
    p_learn_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait_b && cmd_valid && (phase_a[1:0] == 2'b11) && width_cfg[1])
        |=> dec_err);

    // R2: a pulse only follows a phase B cycle
    p_pulse_after_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_wait_b |=> !dec_valid);

endmodule

// File: tb/tb_cmd_frame_decoder.sv
module tb_cmd_frame_decoder;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [8:0] cmd_bus;
    logic [1:0] width_cfg;
    logic       dec_valid, dec_err, dec_burst, dec_learn_wide;
    logic [1:0] dec_op, dec_sadr_hi;
    logic [2:0] dec_gmr_idx, dec_cmp_idx, dec_res_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    cmd_frame_decoder dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bus(cmd_bus),
        .width_cfg(width_cfg), .dec_valid(dec_valid), .dec_err(dec_err),
        .dec_op(dec_op), .dec_sadr_hi(dec_sadr_hi), .dec_gmr_idx(dec_gmr_idx),
        .dec_burst(dec_burst), .dec_cmp_idx(dec_cmp_idx),
        .dec_res_idx(dec_res_idx), .dec_learn_wide(dec_learn_wide)
    );

    // {err, valid, op, sadr, gmr, burst, cmp, res, wide}
    function automatic logic [16:0] model(logic [8:0] a, logic [8:0] b, logic [1:0] cfg);
        logic ok;
        logic [1:0] op, sadr;
        logic [2:0] gmr, cmp, res;
        logic burst, wide, w272;
        w272 = cfg[1];
        op = a[1:0]; sadr = a[8:7];
        gmr = 0; cmp = 0; res = 0; burst = 0; wide = 0;
        ok = (a[1:0] == b[1:0]);
        case (a[1:0])
            2'b00: begin
                ok = ok && a[5:3] == 0 && b[8:3] == 0 && a[2] == b[2];
                burst = a[2];
            end
            2'b01: begin
                ok = ok && b[8:6] == 0 && a[5:3] == b[5:3] && a[2] == b[2];
                burst = a[2]; gmr = a[5:3];
            end
            2'b10: begin
                ok = ok && !b[2] && (a[2] == w272);
                gmr = a[5:3]; res = b[8:6]; cmp = b[5:3];
            end
            default: begin
                ok = ok && !w272 && !a[2] && !b[2] && !b[8] && !b[6] && a[5:3] == b[5:3];
                cmp = a[5:3]; wide = b[7];
            end
        endcase
        if (!ok) return {1'b1, 1'b0, 15'd0};
        return {1'b0, 1'b1, op, sadr, gmr, burst, cmp, res, wide};
    endfunction

    function automatic logic [16:0] observed();
        return {dec_err, dec_valid, dec_op, dec_sadr_hi, dec_gmr_idx, dec_burst,
                dec_cmp_idx, dec_res_idx, dec_learn_wide};
    endfunction

    task automatic check(string tag, logic [16:0] act, logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drives a full frame; result is checked after the posedge following phase B
    task automatic send(string tag, logic [8:0] a, logic [8:0] b, logic [1:0] cfg);
        @(negedge clk);
        width_cfg = cfg; cmd_valid = 1'b1; cmd_bus = a;
        @(posedge clk); #1;
        check("R2 no pulse after phase A", observed(), 17'd0);
        @(negedge clk);
        cmd_bus = b;
        @(posedge clk); #1;
        check(tag, observed(), model(a, b, cfg));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0; cmd_bus = $urandom;
            @(posedge clk); #1;
            check("R2 quiet while idle", observed(), 17'd0);
        end
    endtask

    function automatic logic [8:0] mk(logic [2:0] hi, logic [2:0] idx, logic m, logic [1:0] op);
        return {hi, idx, m, op};
    endfunction

    initial begin
        int seed_unused;
        seed_unused = $urandom(32'h1234_5678);
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_bus = '0; width_cfg = 2'b00;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset outputs", observed(), 17'd0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // directed cases
        send("R5 read burst", mk(3'b111, 0, 1, 2'b00), mk(0, 0, 1, 2'b00), 2'b00);
        check("R5 sadr bit19 dropped", {15'd0, dec_sadr_hi}, 17'd3);
        send("R5 write gmr", mk(3'b010, 3'b101, 0, 2'b01), mk(0, 3'b101, 0, 2'b01), 2'b01);
        check("R5 gmr value", {14'd0, dec_gmr_idx}, 17'd5);
        send("R6 read nonzero phase B", mk(0, 0, 0, 2'b00), mk(3'b100, 0, 0, 2'b00), 2'b00);
        send("R6 write nonzero phase B hi", mk(0, 1, 0, 2'b01), mk(3'b001, 1, 0, 2'b01), 2'b00);
        send("R3 opcode mismatch", mk(0, 0, 0, 2'b00), mk(0, 0, 0, 2'b01), 2'b00);
        check("R3 err seen", {16'd0, dec_err}, 17'd1);
        send("R7 search 136", mk(3'b101, 3'b011, 0, 2'b10), mk(3'b110, 3'b001, 0, 2'b10), 2'b01);
        check("R7 res idx", {14'd0, dec_res_idx}, 17'd6);
        send("R7 search 272 ok", mk(0, 2, 1, 2'b10), mk(1, 4, 0, 2'b10), 2'b10);
        check("R7 valid 272", {16'd0, dec_valid}, 17'd1);
        send("R7 search 272 flag missing", mk(0, 2, 0, 2'b10), mk(1, 4, 0, 2'b10), 2'b10);
        send("R7 search flag set in 68", mk(0, 2, 1, 2'b10), mk(1, 4, 0, 2'b10), 2'b00);
        send("R8 learn wide", mk(3'b011, 3'b111, 0, 2'b11), mk(3'b010, 3'b111, 0, 2'b11), 2'b01);
        check("R8 learn_wide bit", {16'd0, dec_learn_wide}, 17'd1);
        send("R8 learn rejected in 272", mk(0, 1, 0, 2'b11), mk(0, 1, 0, 2'b11), 2'b11);
        check("R8 err seen", {16'd0, dec_err}, 17'd1);
        send("R9 burst disagree", mk(0, 0, 1, 2'b00), mk(0, 0, 0, 2'b00), 2'b00);
        send("R9 gmr disagree", mk(0, 3, 0, 2'b01), mk(0, 2, 0, 2'b01), 2'b00);

        // R4: strobe dropped after phase A
        @(negedge clk); cmd_valid = 1'b1; cmd_bus = mk(0, 0, 0, 2'b00);
        @(negedge clk); cmd_valid = 1'b0;
        @(posedge clk); #1;
        check("R4 drop error", observed(), {1'b1, 16'd0});
        // R10: next strobe right away is a new phase A
        send("R10 frame after abort", mk(3'b100, 0, 0, 2'b01), mk(0, 0, 0, 2'b01), 2'b00);
        check("R10 valid after abort", {16'd0, dec_valid}, 17'd1);

        // constrained random, mostly back to back
        for (int n = 0; n < 400; n++) begin
            logic [1:0] op, cfg;
            logic [2:0] hi, idx, idx2, res;
            logic m, w;
            logic [8:0] a, b;
            op = 2'($urandom); cfg = 2'($urandom);
            hi = 3'($urandom); idx = 3'($urandom); idx2 = 3'($urandom);
            res = 3'($urandom); m = 1'($urandom); w = 1'($urandom);
            case (op)
                2'b00: begin a = mk(hi, 0, m, op); b = mk(0, 0, m, op); end
                2'b01: begin a = mk(hi, idx, m, op); b = mk(0, idx, m, op); end
                2'b10: begin a = mk(hi, idx, cfg[1], op); b = mk(res, idx2, 0, op); end
                default: begin a = mk(hi, idx, 0, op); b = mk({1'b0, w, 1'b0}, idx, 0, op); end
            endcase
            if ($urandom_range(3) == 0) begin
                int bitpos;
                bitpos = $urandom_range(17);
                if (bitpos < 9) a[bitpos] = ~a[bitpos];
                else b[bitpos-9] = ~b[bitpos-9];
            end
            case (op)
                2'b00, 2'b01: send("R5 R6 R9 random read/write", a, b, cfg);
                2'b10: send("R7 random search", a, b, cfg);
                default: send("R8 random learn", a, b, cfg);
            endcase
            if ($urandom_range(7) == 0) idle(1);
        end

        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule